// File: doc/BRIEF.md
# Banked Register Window

This block maps a larger internal register space onto a small host address window. The host sees eight byte addresses. The internal register file holds seventeen byte registers, indexed 0x00 to 0x10. A bank state picks which slice of the internal space the window shows. The host changes the bank by writing the control register, which always sits at host address 7.

A single write to address 7 selects a bank from bit 7 of the written byte. A set bit selects bank 1 and a clear bit selects bank 0. Two writes to address 7 with no other access between them select bank 2. The second write selects bank 2 whatever its bit 7 holds. A read of any address, or a write to any other address, cancels a pending double write.

The block holds a simple register file so that the mapping can be observed. It also drives the decoded internal index and a select strobe toward the register file side. The meaning of the stored bytes is outside its scope.

Top module: `banked_reg_window`

## Requirements
- R1: After reset the bank is 0, every internal register holds 0x00 and `host_rdata` is 0x00.
- R2: In bank 0, host addresses 0 to 6 reach internal registers 0x00 to 0x06.
- R3: A write to address 7 with bit 7 set selects bank 1, unless it directly follows another write to address 7. In bank 1, host addresses 0 to 6 reach internal registers 0x08 to 0x0E.
- R4: A write to address 7 that directly follows another write to address 7 selects bank 2, whatever the value of its bit 7. Further back-to-back writes to address 7 keep bank 2. In bank 2, host address 0 reaches internal register 0x10.
- R5: Any read, or any write to an address other than 7, between two writes to address 7 cancels the bank-2 sequence. The second write then acts as a single write.
- R6: A write to address 7 with bit 7 clear returns to bank 0, unless it directly follows another write to address 7.
- R7: Host address 7 reaches internal register 0x07 in every bank. It stores and reads back all eight written bits.
- R8: In bank 2, host addresses 1 to 6 have no register. Reads there return 0x00, and writes there change no register.
- R9: `host_rdata` takes the read value on the clock edge that samples `host_rd`. It holds that value at all other times.
- R10: `reg_idx` shows the internal index that the current address decodes to. `reg_sel` is high only when a strobe is active and that index is implemented.
- R11: When `host_wr` and `host_rd` are high in the same cycle, the write is performed and the read is ignored, so `host_rdata` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Host window address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, one access per high cycle |
| host_rd | input | 1 | Read strobe, one access per high cycle |
| host_rdata | output | 8 | Registered read data |
| reg_idx | output | 5 | Internal register index decoded from the current address |
| reg_sel | output | 1 | Strobe active and the index is implemented |

## Verification
The bench targets how two writes to address 7 are told apart. One case has the writes back to back. Another puts a read between them, and another puts a write to a different address between them. A design that ignored the cancel would end in bank 2 when it should stay in bank 1 or bank 0. A design that looked only at bit 7 would never reach bank 2 with a cleared byte.

Each bank is read back after the host leaves and re-enters it. A decoder that aliased banks would return another bank's byte. The empty slots of bank 2 are written and then read as zero, and bank 0 is checked to be unchanged. A decoder that wrapped the index would corrupt a low register there. Simultaneous strobes and idle cycles check that the read port holds its value.

// File: rtl/banked_reg_window.sv
module banked_reg_window #(
  parameter int DW        = 8,
  parameter int AW        = 3,
  parameter int NREGS     = 17,
  parameter int CTRL_ADDR = 7,
  parameter int BANK_BIT  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  input  logic            host_wr,
  input  logic            host_rd,
  output logic [DW-1:0]   host_rdata,
  output logic [AW+1:0]   reg_idx,
  output logic            reg_sel
);

  localparam int FULLW = AW + 2;
  localparam logic [FULLW-1:0] LIMIT  = FULLW'(NREGS);
  localparam logic [AW-1:0]    CADDR  = AW'(CTRL_ADDR);
  localparam logic [FULLW-1:0] CIDX   = FULLW'(CTRL_ADDR);
  localparam logic [1:0]       BANK0  = 2'd0;
  localparam logic [1:0]       BANK1  = 2'd1;
  localparam logic [1:0]       BANK2  = 2'd2;

  logic [1:0]       bank_q;
  logic             armed_q;
  logic [DW-1:0]    regs [NREGS];
  logic [DW-1:0]    rdata_q;
  logic [FULLW-1:0] idx;
  logic             idx_ok;
  logic [DW-1:0]    rd_val;

  wire is_ctrl  = (host_addr == CADDR);
  wire wr_ctrl  = host_wr && is_ctrl;
  wire any_acc  = host_wr || host_rd;
  wire rd_only  = host_rd && !host_wr;

  always_comb begin
    if (is_ctrl) begin
      idx    = CIDX;
      idx_ok = 1'b1;
    end else begin
      idx    = {bank_q, host_addr};
      idx_ok = (idx < LIMIT);
    end
  end

  assign reg_idx = idx;
  assign reg_sel = any_acc && idx_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q  <= BANK0;
      armed_q <= 1'b0;
    end else if (wr_ctrl) begin
      armed_q <= 1'b1;
      if (armed_q)
        bank_q <= BANK2;
      else
        bank_q <= host_wdata[BANK_BIT] ? BANK1 : BANK0;
    end else if (any_acc) begin
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (host_wr && idx_ok) begin
      regs[idx] <= host_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (idx_ok) rd_val = regs[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_only) rdata_q <= rd_val;
  end

  assign host_rdata = rdata_q;

  AST_BANK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q != 2'd3); // R4
  AST_BANK1_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !armed_q && host_wdata[BANK_BIT]) |=> bank_q == BANK1); // R3
  AST_BANK2_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && armed_q) |=> bank_q == BANK2); // R4
  AST_ARM_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && !wr_ctrl) |=> !armed_q); // R5
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(bank_q)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_only |=> $stable(host_rdata)); // R9
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && !idx_ok) |=> host_rdata == '0); // R8
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_idx < LIMIT)); // R10

endmodule

// File: tb/banked_reg_window_test.sv
`timescale 1ns/1ps
module banked_reg_window_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic [4:0] reg_idx;
  logic       reg_sel;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  banked_reg_window uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .reg_idx(reg_idx), .reg_sel(reg_sel)
  );

  // {req[3:0], op[1:0] (1 write, 2 read+check), addr[2:0], data[7:0], expect[7:0]}
  localparam int NV = 46;
  localparam logic [24:0] VEC [NV] = '{
    {4'd2, 2'd1, 3'd0, 8'h11, 8'h00},  // R2
    {4'd2, 2'd1, 3'd6, 8'h66, 8'h00},
    {4'd2, 2'd1, 3'd7, 8'h05, 8'h00},
    {4'd2, 2'd2, 3'd0, 8'h00, 8'h11},
    {4'd2, 2'd2, 3'd6, 8'h00, 8'h66},
    {4'd7, 2'd2, 3'd7, 8'h00, 8'h05},  // R7
    {4'd3, 2'd1, 3'd7, 8'h85, 8'h00},  // R3 bank 1
    {4'd3, 2'd1, 3'd0, 8'hA0, 8'h00},
    {4'd3, 2'd1, 3'd6, 8'hA6, 8'h00},
    {4'd3, 2'd2, 3'd0, 8'h00, 8'hA0},
    {4'd3, 2'd2, 3'd6, 8'h00, 8'hA6},
    {4'd7, 2'd2, 3'd7, 8'h00, 8'h85},
    {4'd6, 2'd1, 3'd7, 8'h05, 8'h00},  // R6 back to bank 0
    {4'd6, 2'd2, 3'd0, 8'h00, 8'h11},
    {4'd6, 2'd2, 3'd6, 8'h00, 8'h66},
    {4'd4, 2'd1, 3'd7, 8'h05, 8'h00},  // R4 double write
    {4'd4, 2'd1, 3'd7, 8'h05, 8'h00},
    {4'd4, 2'd1, 3'd0, 8'hB0, 8'h00},
    {4'd4, 2'd2, 3'd0, 8'h00, 8'hB0},
    {4'd8, 2'd1, 3'd3, 8'h33, 8'h00},  // R8 empty slot
    {4'd8, 2'd2, 3'd3, 8'h00, 8'h00},
    {4'd7, 2'd2, 3'd7, 8'h00, 8'h05},
    {4'd6, 2'd1, 3'd7, 8'h00, 8'h00},
    {4'd6, 2'd2, 3'd0, 8'h00, 8'h11},
    {4'd8, 2'd2, 3'd3, 8'h00, 8'h00},
    {4'd5, 2'd1, 3'd7, 8'h01, 8'h00},  // R5 cancel by read
    {4'd5, 2'd2, 3'd2, 8'h00, 8'h00},
    {4'd5, 2'd1, 3'd7, 8'h01, 8'h00},
    {4'd5, 2'd2, 3'd0, 8'h00, 8'h11},
    {4'd5, 2'd1, 3'd7, 8'h80, 8'h00},  // R5 cancel by other write
    {4'd5, 2'd1, 3'd1, 8'h12, 8'h00},
    {4'd5, 2'd1, 3'd7, 8'h80, 8'h00},
    {4'd5, 2'd2, 3'd0, 8'h00, 8'hA0},
    {4'd5, 2'd2, 3'd1, 8'h00, 8'h12},
    {4'd7, 2'd2, 3'd7, 8'h00, 8'h80},
    {4'd6, 2'd1, 3'd7, 8'h00, 8'h00},
    {4'd4, 2'd1, 3'd7, 8'h00, 8'h00},
    {4'd4, 2'd1, 3'd7, 8'h00, 8'h00},
    {4'd4, 2'd2, 3'd0, 8'h00, 8'hB0},
    {4'd6, 2'd1, 3'd7, 8'h00, 8'h00},
    {4'd6, 2'd2, 3'd1, 8'h00, 8'h00},
    {4'd4, 2'd1, 3'd7, 8'h81, 8'h00},
    {4'd4, 2'd1, 3'd7, 8'h81, 8'h00},
    {4'd4, 2'd2, 3'd0, 8'h00, 8'hB0},
    {4'd7, 2'd2, 3'd7, 8'h00, 8'h81},
    {4'd8, 2'd2, 3'd6, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic r, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = w; host_rd = r; host_addr = a; host_wdata = d;
    @(posedge clk);
    #1;
    host_wr = 1'b0; host_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 rdata after reset", host_rdata, 8'h00);
    acc(0, 1, 3'd7, 8'h00);
    chk("R1 control after reset", host_rdata, 8'h00);
    acc(0, 1, 3'd0, 8'h00);
    chk("R1 reg0 after reset", host_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      if (v[20:19] == 2'd1) acc(1, 0, v[18:16], v[15:8]);
      else begin
        acc(0, 1, v[18:16], 8'h00);
        chk($sformatf("R%0d vector %0d", v[24:21], i), host_rdata, v[7:0]);
      end
    end

    // back to bank 0
    acc(0, 1, 3'd7, 8'h00);
    acc(1, 0, 3'd7, 8'h00);
    acc(0, 1, 3'd0, 8'h00);
    chk("R6 bank0 reg0", host_rdata, 8'h11);

    // R11 simultaneous strobes
    acc(1, 1, 3'd0, 8'h5A);
    chk("R11 read ignored", host_rdata, 8'h11);
    acc(0, 1, 3'd0, 8'h00);
    chk("R11 write done", host_rdata, 8'h5A);

    // R9 hold over idle cycles
    repeat (3) @(posedge clk);
    #1 chk("R9 rdata holds", host_rdata, 8'h5A);

    // R10 decode outputs, bank 1
    acc(1, 0, 3'd7, 8'h80);
    @(negedge clk);
    host_addr = 3'd3;
    #1 chk("R10 idle sel low", {7'd0, reg_sel}, 8'h00);
    host_rd = 1'b1;
    #1 chk("R10 bank1 index", {3'd0, reg_idx}, 8'h0B);
    chk("R10 bank1 sel", {7'd0, reg_sel}, 8'h01);
    @(posedge clk);
    #1 host_rd = 1'b0;
    acc(1, 0, 3'd7, 8'h80);
    acc(1, 0, 3'd7, 8'h80);
    @(negedge clk);
    host_addr = 3'd5; host_rd = 1'b1;
    #1 chk("R10 bank2 empty sel", {7'd0, reg_sel}, 8'h00);
    host_addr = 3'd0;
    #1 chk("R10 bank2 index", {3'd0, reg_idx}, 8'h10);
    chk("R10 bank2 sel", {7'd0, reg_sel}, 8'h01);
    @(posedge clk);
    #1 host_rd = 1'b0;
    chk("R4 bank2 reg16", host_rdata, 8'hB0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule